// File: doc/BRIEF.md
# Serial Core Status and Interrupt Collector

This block collects the condition reports of a FIFO-based serial engine into three readable flag registers and drives one active-high, level-sensitive interrupt line. The first register holds transfer progress: sticky bits for service requests and for the end of a counted transfer, next to live FIFO level indications. The second holds FIFO overrun and underrun errors. The third holds errors of the serial clock logic. The FIFO and counter logic send one-cycle event pulses and steady level signals into the block.

Software reads a flag register and then writes the same value back to acknowledge it. Each sticky bit clears where the written value has a 1, and the other bits keep their state. A mask register can keep the progress flags away from the interrupt. Two enable registers decide which error flags reach the interrupt. The serial error enable comes out of reset with both of its bits set. The progress mask and the FIFO error enable come out of reset at zero. Register access is a single-cycle write strobe with an address. Read data follows the address combinationally.

Top module: `stat_irq_unit`

## Requirements
- R1: After reset, every flag register reads 0, the progress mask (address 1) reads 0, the FIFO error enable (address 3) reads 0, the serial error enable (address 5) reads 0x3, and `irq` is 0.
- R2: Each progress pulse sets a sticky bit in the progress register (address 0), visible from the cycle after the pulse: `outSvcEvt` sets bit 8, `inSvcEvt` sets bit 9, `outDoneEvt` sets bit 10, `inDoneEvt` sets bit 11.
- R3: Bits 4 to 7 of address 0 follow the live levels `outNotEmpty` (4), `inNotEmpty` (5), `outFull` (6), `inFull` (7). A write to these bits has no effect, and it sets no sticky bit.
- R4: A write to a flag register clears exactly the sticky bits that have a 1 in the written data. All other bits keep their state.
- R5: If an event pulse and a write clearing the same bit occur in the same cycle, the bit ends up set.
- R6: FIFO error pulses set bits of address 2: `inOverrunEvt` sets bit 2, `outUnderrunEvt` bit 3, `inUnderrunEvt` bit 4, `outOverrunEvt` bit 5. They clear by write-back.
- R7: Serial clock error pulses set bits of address 4: `clkUnderrunEvt` sets bit 0, `clkOverrunEvt` sets bit 1. They clear by write-back.
- R8: `irq` is high while any progress flag (bits 8 to 11) is set whose bit in the mask register (address 1, same positions) is 0.
- R9: `irq` is high while any FIFO error flag is set whose bit in address 3 is 1, or any serial error flag is set whose bit in address 5 is 1. With no qualifying flag set, `irq` is 0.
- R10: Only bits 8 to 11 of the mask, bits 2 to 5 of the FIFO error enable and bits 0 to 1 of the serial error enable are stored. All other bits of every register read 0. A register keeps its value unless its own address is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address for write and read |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data of the addressed register |
| outSvcEvt | input | 1 | Output FIFO needs service (pulse) |
| inSvcEvt | input | 1 | Input FIFO needs service (pulse) |
| outDoneEvt | input | 1 | Output count reached (pulse) |
| inDoneEvt | input | 1 | Input count reached (pulse) |
| outNotEmpty | input | 1 | Output FIFO holds data (level) |
| inNotEmpty | input | 1 | Input FIFO holds data (level) |
| outFull | input | 1 | Output FIFO full (level) |
| inFull | input | 1 | Input FIFO full (level) |
| inOverrunEvt | input | 1 | Input FIFO overrun (pulse) |
| outUnderrunEvt | input | 1 | Output FIFO underrun (pulse) |
| inUnderrunEvt | input | 1 | Input FIFO underrun (pulse) |
| outOverrunEvt | input | 1 | Output FIFO overrun (pulse) |
| clkUnderrunEvt | input | 1 | Serial clock underrun (pulse) |
| clkOverrunEvt | input | 1 | Serial clock overrun (pulse) |
| irq | output | 1 | Level interrupt, active high |

## Verification
The hardest case to reach from the ports is a sticky bit that receives an event and a clear in the same cycle. The bench reaches it by raising the event pulse and the write strobe on the same falling edge, with the write data holding a 1 at that bit. It then reads the bit back after the clock edge. The mask and enable gating is covered by a sweep. With every progress flag held set, the bench writes all sixteen mask values and checks `irq` against a value computed from each mask. It also sets each error flag with its enable off and then on, so each flag is seen both with and without reaching the interrupt.

// File: rtl/stat_irq_pkg.sv
package stat_irq_pkg;
  localparam int REG_W  = 32;
  localparam int ADDR_W = 3;

  localparam int OP_SVC_LSB = 8;
  localparam int OP_SVC_N   = 4;
  localparam int OP_LVL_LSB = 4;
  localparam int OP_LVL_N   = 4;
  localparam int CERR_LSB   = 2;
  localparam int CERR_N     = 4;
  localparam int SERR_LSB   = 0;
  localparam int SERR_N     = 2;

  localparam logic [ADDR_W-1:0] ADR_OP    = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_MASK  = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_CERR  = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_CEN   = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_SERR  = 3'd4;
  localparam logic [ADDR_W-1:0] ADR_SEN   = 3'd5;

  localparam logic [SERR_N-1:0] SEN_RESET = '1;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_OP, SEL_MASK, SEL_CERR, SEL_CEN, SEL_SERR, SEL_SEN
  } rd_sel_e;

  typedef struct packed {
    logic    wrOp;
    logic    wrMask;
    logic    wrCerr;
    logic    wrCen;
    logic    wrSerr;
    logic    wrSen;
    rd_sel_e rdSel;
  } strobe_t;
endpackage

// File: rtl/stat_sticky_bank.sv
module stat_sticky_bank #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] setEvt,
  input  logic [WIDTH-1:0] clrReq,
  output logic [WIDTH-1:0] flags
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rstN)          flags[i] <= 1'b0;
      else if (setEvt[i]) flags[i] <= 1'b1;
      else if (clrReq[i]) flags[i] <= 1'b0;
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
      setEvt[i] |=> flags[i]); // R5
    AST_CLEAR_ONE: assert property (@(posedge clk) disable iff (!rstN)
      (clrReq[i] && !setEvt[i]) |=> !flags[i]); // R4
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
      (!clrReq[i] && !setEvt[i]) |=> $stable(flags[i])); // R2
  end
endmodule

// File: rtl/stat_irq_ctrl.sv
module stat_irq_ctrl
  import stat_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  output strobe_t           strobe
);
  always_comb begin
    strobe        = '0;
    strobe.rdSel  = SEL_NONE;
    unique case (regAddr)
      ADR_OP:   begin strobe.rdSel = SEL_OP;   strobe.wrOp   = regWrEn; end
      ADR_MASK: begin strobe.rdSel = SEL_MASK; strobe.wrMask = regWrEn; end
      ADR_CERR: begin strobe.rdSel = SEL_CERR; strobe.wrCerr = regWrEn; end
      ADR_CEN:  begin strobe.rdSel = SEL_CEN;  strobe.wrCen  = regWrEn; end
      ADR_SERR: begin strobe.rdSel = SEL_SERR; strobe.wrSerr = regWrEn; end
      ADR_SEN:  begin strobe.rdSel = SEL_SEN;  strobe.wrSen  = regWrEn; end
      default:  strobe.rdSel = SEL_NONE;
    endcase
  end

  AST_ONE_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.wrOp, strobe.wrMask, strobe.wrCerr,
              strobe.wrCen, strobe.wrSerr, strobe.wrSen})); // R10
endmodule

// File: rtl/stat_irq_dp.sv
module stat_irq_dp
  import stat_irq_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             strobe,
  input  logic [REG_W-1:0]    regWrData,
  input  logic [OP_SVC_N-1:0] opEvt,
  input  logic [OP_LVL_N-1:0] opLvl,
  input  logic [CERR_N-1:0]   cerrEvt,
  input  logic [SERR_N-1:0]   serrEvt,
  output logic [REG_W-1:0]    regRdData,
  output logic                irq
);
  logic [OP_SVC_N-1:0] opFlags, opClr, opMask;
  logic [CERR_N-1:0]   cerrFlags, cerrClr, cerrEn;
  logic [SERR_N-1:0]   serrFlags, serrClr, serrEn;

  assign opClr   = strobe.wrOp   ? regWrData[OP_SVC_LSB +: OP_SVC_N] : '0;
  assign cerrClr = strobe.wrCerr ? regWrData[CERR_LSB +: CERR_N]     : '0;
  assign serrClr = strobe.wrSerr ? regWrData[SERR_LSB +: SERR_N]     : '0;

  stat_sticky_bank #(.WIDTH(OP_SVC_N)) u_opBank (
    .clk(clk), .rstN(rstN), .setEvt(opEvt), .clrReq(opClr), .flags(opFlags));
  stat_sticky_bank #(.WIDTH(CERR_N)) u_cerrBank (
    .clk(clk), .rstN(rstN), .setEvt(cerrEvt), .clrReq(cerrClr), .flags(cerrFlags));
  stat_sticky_bank #(.WIDTH(SERR_N)) u_serrBank (
    .clk(clk), .rstN(rstN), .setEvt(serrEvt), .clrReq(serrClr), .flags(serrFlags));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opMask <= '0;
      cerrEn <= '0;
      serrEn <= SEN_RESET;
    end else begin
      if (strobe.wrMask) opMask <= regWrData[OP_SVC_LSB +: OP_SVC_N];
      if (strobe.wrCen)  cerrEn <= regWrData[CERR_LSB +: CERR_N];
      if (strobe.wrSen)  serrEn <= regWrData[SERR_LSB +: SERR_N];
    end
  end

  always_comb begin
    regRdData = '0;
    unique case (strobe.rdSel)
      SEL_OP: begin
        regRdData[OP_SVC_LSB +: OP_SVC_N] = opFlags;
        regRdData[OP_LVL_LSB +: OP_LVL_N] = opLvl;
      end
      SEL_MASK: regRdData[OP_SVC_LSB +: OP_SVC_N] = opMask;
      SEL_CERR: regRdData[CERR_LSB +: CERR_N]     = cerrFlags;
      SEL_CEN:  regRdData[CERR_LSB +: CERR_N]     = cerrEn;
      SEL_SERR: regRdData[SERR_LSB +: SERR_N]     = serrFlags;
      SEL_SEN:  regRdData[SERR_LSB +: SERR_N]     = serrEn;
      default:  regRdData = '0;
    endcase
  end

  assign irq = (|(opFlags & ~opMask)) | (|(cerrFlags & cerrEn)) | (|(serrFlags & serrEn));

  AST_SEN_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.wrSen |=> $stable(serrEn)); // R10
  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.wrMask |=> $stable(opMask)); // R10
  AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> ((|opFlags) || (|cerrFlags) || (|serrFlags))); // R9
endmodule

// File: rtl/stat_irq_unit.sv
module stat_irq_unit
  import stat_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [REG_W-1:0]  regWrData,
  output logic [REG_W-1:0]  regRdData,
  input  logic              outSvcEvt,
  input  logic              inSvcEvt,
  input  logic              outDoneEvt,
  input  logic              inDoneEvt,
  input  logic              outNotEmpty,
  input  logic              inNotEmpty,
  input  logic              outFull,
  input  logic              inFull,
  input  logic              inOverrunEvt,
  input  logic              outUnderrunEvt,
  input  logic              inUnderrunEvt,
  input  logic              outOverrunEvt,
  input  logic              clkUnderrunEvt,
  input  logic              clkOverrunEvt,
  output logic              irq
);
  strobe_t strobe;

  stat_irq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr), .strobe(strobe));

  stat_irq_dp u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .regWrData(regWrData),
    .opEvt({inDoneEvt, outDoneEvt, inSvcEvt, outSvcEvt}),
    .opLvl({inFull, outFull, inNotEmpty, outNotEmpty}),
    .cerrEvt({outOverrunEvt, inUnderrunEvt, outUnderrunEvt, inOverrunEvt}),
    .serrEvt({clkOverrunEvt, clkUnderrunEvt}),
    .regRdData(regRdData), .irq(irq));
endmodule

// File: tb/stat_irq_unit_tb.sv
module stat_irq_unit_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [9:0]  ev = '0;
  logic [3:0]  lvl = '0;
  logic        irq;
  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stat_irq_unit u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData),
    .outSvcEvt(ev[0]), .inSvcEvt(ev[1]), .outDoneEvt(ev[2]), .inDoneEvt(ev[3]),
    .outNotEmpty(lvl[0]), .inNotEmpty(lvl[1]), .outFull(lvl[2]), .inFull(lvl[3]),
    .inOverrunEvt(ev[4]), .outUnderrunEvt(ev[5]), .inUnderrunEvt(ev[6]),
    .outOverrunEvt(ev[7]), .clkUnderrunEvt(ev[8]), .clkOverrunEvt(ev[9]),
    .irq(irq));

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(posedge clk); @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic pulse(input int i);
    ev[i] = 1'b1;
    @(posedge clk); @(negedge clk);
    ev[i] = 1'b0;
  endtask

  function automatic logic [2:0] evAddr(int i);
    if (i < 4) return 3'd0;
    if (i < 8) return 3'd2;
    return 3'd4;
  endfunction

  function automatic logic [31:0] evBit(int i);
    if (i < 4) return 32'h1 << (8 + i);
    if (i < 8) return 32'h1 << (2 + i - 4);
    return 32'h1 << (i - 8);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog got=running exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset values
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), d);
      check("R1", d, (a == 5) ? 32'h3 : 32'h0);
    end
    check("R1 irq", {31'b0, irq}, 32'h0);

    // R2 R6 R7 event mapping, R4 write-back clear, R9 enable gating
    wr(3'd3, 32'h3C);
    for (int i = 0; i < 10; i++) begin
      pulse(i);
      rd(evAddr(i), d);
      check(i < 4 ? "R2" : (i < 8 ? "R6" : "R7"), d, evBit(i));
      check(i < 4 ? "R8" : "R9", {31'b0, irq}, 32'h1);
      wr(evAddr(i), d);
      rd(evAddr(i), d);
      check("R4", d, 32'h0);
      check("R4 irq", {31'b0, irq}, 32'h0);
    end

    // R9 disabled error enables keep irq low
    wr(3'd3, 32'h0); wr(3'd5, 32'h0);
    for (int i = 4; i < 10; i++) begin
      pulse(i);
      check("R9 off", {31'b0, irq}, 32'h0);
      rd(evAddr(i), d);
      check("R9 flag", d, evBit(i));
      wr(evAddr(i), d);
    end
    wr(3'd5, 32'h3);

    // R3 live levels, writes ignored
    for (int m = 0; m < 16; m++) begin
      lvl = 4'(m);
      rd(3'd0, d);
      check("R3", d, 32'(m) << 4);
      wr(3'd0, 32'hFF0);
      rd(3'd0, d);
      check("R3 wr", d, 32'(m) << 4);
      check("R3 irq", {31'b0, irq}, 32'h0);
    end
    lvl = '0;

    // R8 mask sweep with all progress flags set
    for (int i = 0; i < 4; i++) pulse(i);
    for (int m = 0; m < 16; m++) begin
      wr(3'd1, 32'hFFFF_F0FF & (32'(m) << 8) | (32'(m) << 8) | 32'hF000_00FF);
      rd(3'd1, d);
      check("R10 mask", d, 32'(m) << 8);
      check("R8", {31'b0, irq}, {31'b0, (m != 15)});
    end
    wr(3'd1, 32'h0);

    // R4 partial clear keeps other bits
    wr(3'd0, 32'h500);
    rd(3'd0, d);
    check("R4 partial", d, 32'hA00);

    // R5 event and clear on the same bit in the same cycle
    ev[1] = 1'b1;
    wr(3'd0, 32'hA00);
    ev[1] = 1'b0;
    rd(3'd0, d);
    check("R5", d, 32'h200);
    wr(3'd0, 32'h200);
    ev[9] = 1'b1;
    wr(3'd4, 32'h2);
    ev[9] = 1'b0;
    rd(3'd4, d);
    check("R5 serial", d, 32'h2);
    wr(3'd4, 32'h2);

    // R10 unused bits and writes to other addresses
    wr(3'd3, 32'hFFFF_FFFF);
    rd(3'd3, d); check("R10 cen", d, 32'h3C);
    wr(3'd5, 32'hFFFF_FFFC);
    rd(3'd5, d); check("R10 sen", d, 32'h0);
    wr(3'd6, 32'hFFFF_FFFF);
    rd(3'd6, d); check("R10 hole", d, 32'h0);
    rd(3'd3, d); check("R10 keep", d, 32'h3C);
    rd(3'd1, d); check("R10 keep mask", d, 32'h0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule